// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block is the tail end of an I2C master. After a byte has been received it drives the acknowledge bit. At the end of a transfer it produces the Stop condition. Software, or a higher-level controller, raises one of two single-cycle requests. The block then runs the whole bus sequence by itself. When the sequence is over it drops its enable flag again and raises a sticky interrupt flag.

All timing comes from an internal down-counter that is loaded with a programmable reload value R, so one bit period is R+1 clock cycles. Both bus lines are open-drain. An output-enable of 1 pulls the line low, and an output-enable of 0 lets the external pull-up take the line high. Both lines are sampled back through a synchronizer of SYNC_STAGES flops. Every phase that releases a line waits until that line is actually seen at its new level, so a slave that stretches SCL simply lengthens the sequence.

A small transmit buffer sits beside the sequencer. A write to it while a sequence runs is refused and sets a collision flag. The reload value must be at least SYNC_STAGES-1 so that a released line is never judged on a stale sample.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: After reset, scl_oe, sda_oe, ack_busy, stop_busy, irq_flag, stop_flag and wcol_flag are 0, and txbuf_q is 0.
- R2: An acknowledge request accepted while idle sets scl_oe=1, ack_busy=1 and sda_oe equal to the inverse of ack_bit on the next edge. ack_bit=0 gives ACK (SDA pulled low) and ack_bit=1 gives NACK (SDA released). scl_oe then stays 1 for exactly R+1 cycles.
- R3: Once SCL is released, the high phase is timed only from the point where the SCL line is sampled high. scl_oe returns to 1 exactly S+SYNC_STAGES+R+2 cycles after the release, where S is the number of cycles a slave held the line low after the release.
- R4: On the edge where scl_oe returns to 1 at the end of an acknowledge, ack_busy falls and irq_flag rises. scl_oe then stays 1 while idle.
- R5: A stop request accepted while idle sets stop_busy=1, scl_oe=1 and sda_oe=1 on the next edge. With SDA previously released, SCL is released SYNC_STAGES+R+2 cycles later.
- R6: During a stop, SDA is released exactly S+SYNC_STAGES+R+2 cycles after SCL is released, with S defined as in R3.
- R7: stop_flag rises SYNC_STAGES+1 cycles after SDA is released, provided both lines read high. R+1 cycles after that, stop_busy falls, irq_flag rises, and both output-enables are 0.
- R8: A buffer write while ack_busy or stop_busy is 1 sets wcol_flag and leaves txbuf_q unchanged. A write while idle loads txbuf_q on the next edge and leaves wcol_flag unchanged.
- R9: irq_flag, stop_flag and wcol_flag stay set until their own clear input is pulsed. The flag is 0 on the edge after the pulse.
- R10: If both requests are raised in the same cycle, the acknowledge runs and the stop request is dropped. stop_busy and stop_flag stay 0.
- R11: A request raised while a sequence is running is ignored. It does not start once the running sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reload | input | CNT_W | Bit-period counter reload value R |
| ack_req | input | 1 | Single-cycle acknowledge request |
| ack_bit | input | 1 | 0 = ACK, 1 = NACK |
| stop_req | input | 1 | Single-cycle stop request |
| txbuf_wr | input | 1 | Transmit buffer write strobe |
| txbuf_wdata | input | DATA_W | Transmit buffer write data |
| clr_irq | input | 1 | Clears irq_flag |
| clr_stop | input | 1 | Clears stop_flag |
| clr_wcol | input | 1 | Clears wcol_flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| ack_busy | output | 1 | Acknowledge sequence in progress, clears itself |
| stop_busy | output | 1 | Stop sequence in progress, clears itself |
| irq_flag | output | 1 | Sticky sequence-complete flag |
| stop_flag | output | 1 | Sticky stop-detected flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| txbuf_q | output | DATA_W | Transmit buffer contents |

## Verification
A sequencer state that is wrong, or stuck in a wait, shows up as a phase whose length on scl_oe or sda_oe is off from R+1, or from S+SYNC_STAGES+R+2. It also shows up as a busy flag that never drops. The bench sweeps R, the stretch length and the ACK/NACK bit, and measures every phase to the exact cycle. A counter that loads or decrements wrongly is therefore seen within one bit period. A premature or missing flag is seen at the edge where the flag should change. A collision-gating fault is seen one cycle after the offending write.

// File: rtl/i2c_as_pkg.sv
package i2c_as_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACK_LO,
    ST_ACK_REL,
    ST_ACK_HI,
    ST_STP_SDA,
    ST_STP_CNT1,
    ST_STP_SCLREL,
    ST_STP_CNT2,
    ST_STP_SDAREL,
    ST_STP_CNT3
  } seq_state_t;
endpackage

// File: rtl/i2c_as_sync.sv
module i2c_as_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_as_brg.sv
module i2c_as_brg #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             halt,
  input  logic [CNT_W-1:0] reload,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= reload;
      run <= 1'b1;
    end else if (halt) begin
      run <= 1'b0;
    end else if (run && cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign tick = run && (cnt == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (run && cnt == $past(reload)));
  assert_count_R2: assert property (@(posedge clk) disable iff (rst)
    (run && cnt != '0 && !load && !halt) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/i2c_as_fsm.sv
module i2c_as_fsm
  import i2c_as_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ack_req,
  input  logic ack_bit,
  input  logic stop_req,
  input  logic scl_s,
  input  logic sda_s,
  input  logic tick,
  output logic brg_load,
  output logic brg_halt,
  output logic scl_oe,
  output logic sda_oe,
  output logic ack_busy,
  output logic stop_busy,
  output logic stop_set,
  output logic done_set
);
  seq_state_t state, nxt;
  logic       scl_n, sda_n;

  always_comb begin
    nxt      = state;
    scl_n    = scl_oe;
    sda_n    = sda_oe;
    brg_load = 1'b0;
    brg_halt = 1'b0;
    stop_set = 1'b0;
    done_set = 1'b0;
    case (state)
      ST_IDLE: begin
        if (ack_req) begin
          nxt      = ST_ACK_LO;
          brg_load = 1'b1;
          scl_n    = 1'b1;
          sda_n    = ~ack_bit;
        end else if (stop_req) begin
          nxt   = ST_STP_SDA;
          scl_n = 1'b1;
          sda_n = 1'b1;
        end
      end
      ST_ACK_LO: if (tick) begin
        nxt      = ST_ACK_REL;
        brg_halt = 1'b1;
        scl_n    = 1'b0;
      end
      ST_ACK_REL: if (scl_s) begin
        nxt      = ST_ACK_HI;
        brg_load = 1'b1;
      end
      ST_ACK_HI: if (tick) begin
        nxt      = ST_IDLE;
        brg_halt = 1'b1;
        scl_n    = 1'b1;
        done_set = 1'b1;
      end
      ST_STP_SDA: if (!sda_s) begin
        nxt      = ST_STP_CNT1;
        brg_load = 1'b1;
      end
      ST_STP_CNT1: if (tick) begin
        nxt      = ST_STP_SCLREL;
        brg_halt = 1'b1;
        scl_n    = 1'b0;
      end
      ST_STP_SCLREL: if (scl_s) begin
        nxt      = ST_STP_CNT2;
        brg_load = 1'b1;
      end
      ST_STP_CNT2: if (tick) begin
        nxt      = ST_STP_SDAREL;
        brg_halt = 1'b1;
        sda_n    = 1'b0;
      end
      ST_STP_SDAREL: if (sda_s && scl_s) begin
        nxt      = ST_STP_CNT3;
        brg_load = 1'b1;
        stop_set = 1'b1;
      end
      ST_STP_CNT3: if (tick) begin
        nxt      = ST_IDLE;
        brg_halt = 1'b1;
        done_set = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      ack_busy  <= 1'b0;
      stop_busy <= 1'b0;
    end else begin
      state     <= nxt;
      scl_oe    <= scl_n;
      sda_oe    <= sda_n;
      ack_busy  <= (nxt == ST_ACK_LO) || (nxt == ST_ACK_REL) || (nxt == ST_ACK_HI);
      stop_busy <= (nxt == ST_STP_SDA) || (nxt == ST_STP_CNT1) || (nxt == ST_STP_SCLREL) ||
                   (nxt == ST_STP_CNT2) || (nxt == ST_STP_SDAREL) || (nxt == ST_STP_CNT3);
    end
  end

  assert_ack_drive_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && ack_req) |=> (scl_oe && ack_busy && sda_oe == !$past(ack_bit)));
  assert_scl_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK_REL && !scl_s) |=> (state == ST_ACK_REL && !scl_oe));
  assert_stop_seen_R7: assert property (@(posedge clk) disable iff (rst)
    stop_set |-> (scl_s && sda_s && stop_busy && !scl_oe && !sda_oe));
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(ack_busy && stop_busy));
  assert_ignore_stop_R11: assert property (@(posedge clk) disable iff (rst)
    (ack_busy && stop_req) |=> !stop_busy);
endmodule

// File: rtl/i2c_as_flags.sv
module i2c_as_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              txbuf_wr,
  input  logic [DATA_W-1:0] txbuf_wdata,
  input  logic              done_set,
  input  logic              stop_set,
  input  logic              clr_irq,
  input  logic              clr_stop,
  input  logic              clr_wcol,
  output logic              irq_flag,
  output logic              stop_flag,
  output logic              wcol_flag,
  output logic [DATA_W-1:0] txbuf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag  <= 1'b0;
      stop_flag <= 1'b0;
      wcol_flag <= 1'b0;
      txbuf_q   <= '0;
    end else begin
      if (done_set)      irq_flag <= 1'b1;
      else if (clr_irq)  irq_flag <= 1'b0;
      if (stop_set)      stop_flag <= 1'b1;
      else if (clr_stop) stop_flag <= 1'b0;
      if (txbuf_wr && busy) wcol_flag <= 1'b1;
      else if (clr_wcol)    wcol_flag <= 1'b0;
      if (txbuf_wr && !busy) txbuf_q <= txbuf_wdata;
    end
  end

  assert_wcol_R8: assert property (@(posedge clk) disable iff (rst)
    (txbuf_wr && busy) |=> (wcol_flag && txbuf_q == $past(txbuf_q)));
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !clr_irq) |=> irq_flag);
  assert_wcol_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (wcol_flag && !clr_wcol) |=> wcol_flag);
endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq #(
  parameter int CNT_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  reload,
  input  logic              ack_req,
  input  logic              ack_bit,
  input  logic              stop_req,
  input  logic              txbuf_wr,
  input  logic [DATA_W-1:0] txbuf_wdata,
  input  logic              clr_irq,
  input  logic              clr_stop,
  input  logic              clr_wcol,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              ack_busy,
  output logic              stop_busy,
  output logic              irq_flag,
  output logic              stop_flag,
  output logic              wcol_flag,
  output logic [DATA_W-1:0] txbuf_q
);
  logic [1:0] lines_s;
  logic       brg_load, brg_halt, tick, stop_set, done_set;

  i2c_as_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .d({sda_in, scl_in}), .q(lines_s)
  );

  i2c_as_brg #(.CNT_W(CNT_W)) u_brg (
    .clk(clk), .rst(rst), .load(brg_load), .halt(brg_halt),
    .reload(reload), .tick(tick)
  );

  i2c_as_fsm u_fsm (
    .clk(clk), .rst(rst), .ack_req(ack_req), .ack_bit(ack_bit),
    .stop_req(stop_req), .scl_s(lines_s[0]), .sda_s(lines_s[1]), .tick(tick),
    .brg_load(brg_load), .brg_halt(brg_halt), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ack_busy(ack_busy), .stop_busy(stop_busy), .stop_set(stop_set),
    .done_set(done_set)
  );

  i2c_as_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .busy(ack_busy | stop_busy), .txbuf_wr(txbuf_wr),
    .txbuf_wdata(txbuf_wdata), .done_set(done_set), .stop_set(stop_set),
    .clr_irq(clr_irq), .clr_stop(clr_stop), .clr_wcol(clr_wcol),
    .irq_flag(irq_flag), .stop_flag(stop_flag), .wcol_flag(wcol_flag),
    .txbuf_q(txbuf_q)
  );
endmodule

// File: tb/i2c_ackstop_seq_bench.sv
`timescale 1ns/1ps
module i2c_ackstop_seq_bench;
  localparam int SYNC = 2;
  logic       clk = 0, rst = 1;
  logic [7:0] reload = 8'd1;
  logic       ack_req = 0, ack_bit = 0, stop_req = 0, txbuf_wr = 0;
  logic [7:0] txbuf_wdata = 0;
  logic       clr_irq = 0, clr_stop = 0, clr_wcol = 0, stretch = 0;
  logic       scl_oe, sda_oe, ack_busy, stop_busy, irq_flag, stop_flag, wcol_flag;
  logic [7:0] txbuf_q;
  logic       scl_line, sda_line;
  int         checks = 0, failures = 0;

  assign scl_line = !(scl_oe | stretch);
  assign sda_line = !sda_oe;

  always #2 clk = ~clk;

  i2c_ackstop_seq u_i2c_ackstop_seq (
    .clk(clk), .rst(rst), .reload(reload), .ack_req(ack_req), .ack_bit(ack_bit),
    .stop_req(stop_req), .txbuf_wr(txbuf_wr), .txbuf_wdata(txbuf_wdata),
    .clr_irq(clr_irq), .clr_stop(clr_stop), .clr_wcol(clr_wcol),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ack_busy(ack_busy), .stop_busy(stop_busy), .irq_flag(irq_flag),
    .stop_flag(stop_flag), .wcol_flag(wcol_flag), .txbuf_q(txbuf_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    clr_irq = 1; clr_stop = 1; clr_wcol = 1; step();
    clr_irq = 0; clr_stop = 0; clr_wcol = 0;
  endtask

  task automatic run_ack(input int r, input bit d, input int s);
    int n;
    reload = 8'(r); ack_bit = d; ack_req = 1; step(); ack_req = 0;
    chk("R2 scl_oe on request", scl_oe, 1);
    chk("R2 sda_oe follows ack bit", sda_oe, !d);
    chk("R2 ack_busy set", ack_busy, 1);
    n = 0;
    while (scl_oe) begin n++; step(); end
    chk("R2 SCL low length", n, r + 1);
    stretch = (s > 0); n = 0;
    while (!scl_oe) begin if (n == s) stretch = 0; n++; step(); end
    chk("R3 SCL high length with stretch", n, s + SYNC + r + 2);
    chk("R4 ack_busy cleared", ack_busy, 0);
    chk("R4 irq set at end", irq_flag, 1);
    repeat (3) step();
    chk("R4 SCL held low in idle", scl_oe, 1);
    chk("R9 irq sticky", irq_flag, 1);
    clr_irq = 1; step(); clr_irq = 0;
    chk("R9 irq cleared", irq_flag, 0);
  endtask

  task automatic run_stop(input int r, input int s);
    int n;
    reload = 8'(r); stop_req = 1; step(); stop_req = 0;
    chk("R5 stop_busy set", stop_busy, 1);
    chk("R5 scl_oe held", scl_oe, 1);
    chk("R5 sda_oe driven", sda_oe, 1);
    n = 0;
    while (scl_oe) begin n++; step(); end
    chk("R5 SCL release delay", n, SYNC + r + 2);
    stretch = (s > 0); n = 0;
    while (sda_oe) begin if (n == s) stretch = 0; n++; step(); end
    chk("R6 SDA release delay", n, s + SYNC + r + 2);
    n = 0;
    while (!stop_flag) begin n++; step(); end
    chk("R7 stop_flag delay", n, SYNC + 1);
    chk("R7 irq not yet", irq_flag, 0);
    n = 0;
    while (!irq_flag) begin n++; step(); end
    chk("R7 irq delay after stop_flag", n, r + 1);
    chk("R7 stop_busy cleared", stop_busy, 0);
    chk("R7 lines released", {30'd0, scl_oe, sda_oe}, 0);
    clr_irq = 1; clr_stop = 1; step(); clr_irq = 0; clr_stop = 0;
    chk("R9 irq cleared", irq_flag, 0);
    chk("R9 stop_flag cleared", stop_flag, 0);
  endtask

  initial begin
    repeat (3) step();
    rst = 0; step();
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 busy", {30'd0, ack_busy, stop_busy}, 0);
    chk("R1 flags", {29'd0, irq_flag, stop_flag, wcol_flag}, 0);
    chk("R1 txbuf", txbuf_q, 0);

    txbuf_wr = 1; txbuf_wdata = 8'hA5; step(); txbuf_wr = 0;
    chk("R8 idle write loads", txbuf_q, 8'hA5);
    chk("R8 idle write no collision", wcol_flag, 0);

    for (int r = 1; r <= 5; r++)
      for (int s = 0; s <= 2; s++) begin
        run_ack(r, 1'b0, s);
        run_ack(r, 1'b1, s);
        run_stop(r, s);
      end

    // R8: write during an acknowledge is refused
    reload = 8'd3; ack_bit = 1; ack_req = 1; step(); ack_req = 0;
    txbuf_wr = 1; txbuf_wdata = 8'h5A; step(); txbuf_wr = 0;
    chk("R8 collision flag", wcol_flag, 1);
    chk("R8 buffer unchanged", txbuf_q, 8'hA5);
    while (ack_busy) step();
    chk("R9 wcol sticky", wcol_flag, 1);
    clear_all();
    chk("R9 wcol cleared", wcol_flag, 0);

    // R10: simultaneous requests
    ack_bit = 1; ack_req = 1; stop_req = 1; step(); ack_req = 0; stop_req = 0;
    chk("R10 ack served", ack_busy, 1);
    chk("R10 stop dropped", stop_busy, 0);
    while (ack_busy) begin
      if (stop_busy) chk("R10 stop_busy during ack", 1, 0);
      step();
    end
    repeat (4) step();
    chk("R10 no stop after ack", {30'd0, stop_busy, stop_flag}, 0);
    chk("R10 SCL still held", scl_oe, 1);
    clear_all();

    // R11: stop during ack ignored
    ack_req = 1; step(); ack_req = 0; step();
    stop_req = 1; step(); stop_req = 0;
    while (ack_busy) step();
    repeat (4) step();
    chk("R11 stop ignored during ack", stop_busy, 0);
    chk("R11 SCL not released", scl_oe, 1);
    clear_all();

    // R11: ack during stop ignored
    stop_req = 1; step(); stop_req = 0; step();
    ack_req = 1; step(); ack_req = 0;
    while (stop_busy) step();
    repeat (4) step();
    chk("R11 ack ignored during stop", ack_busy, 0);
    chk("R11 lines stay released", {30'd0, scl_oe, sda_oe}, 0);
    clear_all();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule